// File: doc/BRIEF.md
# ECC Error Capture and Reporting Block

This block sits beside a memory controller's ECC checker. On every read beat the checker may flag a correctable single-bit error (SBE) or an uncorrectable multi-bit error (MBE). With each flag it passes the beat's data, check bits and address. The block qualifies each flag with a global ECC-on bit and a per-type mask. It counts correctable errors against a programmable threshold and keeps sticky detect bits that software clears by writing ones. It also drives one interrupt line.

When an error becomes reportable, the block freezes a snapshot of the failing beat: data split into high and low words, check bits and a 64-bit address split into two words. The snapshot stays frozen until software clears every detect bit. The block also holds three injection registers. The write path uses them to flip chosen data and check bits on their way to memory, which lets software test the error path.

Software reaches everything through a simple 32-bit word-addressed register port. Writes take effect on the clock edge. Reads are combinational.

Top module: `ecc_err_mgr`

## Requirements
- R1: After reset every register reads 0 and `irq` is 0. Register word addresses: 0 config, 1 detect, 2 mask, 3 interrupt enable, 4 SBE management, 5 capture data high, 6 capture data low, 7 capture check bits, 8 capture address low, 9 capture address high, 10 inject data high, 11 inject data low, 12 inject control.
- R2: While config bit 0 (ECC on) is 0, beats flagged on `evt_valid` change no detect bit, counter or capture register.
- R3: Mask register bit 0 suppresses SBE handling and bit 1 suppresses MBE handling. Writing 0 enables both.
- R4: An accepted, unmasked MBE sets detect bit 1, visible the cycle after the beat.
- R5: The SBE management register holds the threshold in bits 23:16 and reads the current count in bits 7:0. Each accepted SBE adds one to the count. When the count reaches the threshold, detect bit 0 is set and the count returns to 0. A threshold of 0 reports no SBE. Writing the register clears the count.
- R6: Writing ones to the detect register clears those bits, so 0xFFFFFFFF clears all. If a new error and a clear of the same bit land in one cycle, the error wins.
- R7: `irq` is high exactly when some detect bit is set and its enable is set. Interrupt-enable bit 0 pairs with SBE and bit 1 pairs with MBE.
- R8: A reportable error (an MBE, or the SBE that reaches the threshold) that arrives while all detect bits are clear is captured: data bits 63:32 go to the high word, bits 31:0 to the low word, and the address splits the same way. While any detect bit is set, the capture registers do not change.
- R9: Config bit 1 selects a 32-bit bus, in which case captured check bits keep their low 16 bits. In 64-bit mode (bit 1 = 0) only the low 8 bits are kept and the rest read 0.
- R10: The injection registers read back what was written. While inject-control bit 16 is set, `wr_data_out` = `wr_data_in` XOR {inject high, inject low} and `wr_chk_out` = `wr_chk_in` XOR inject-control bits 15:0. Otherwise both outputs pass their inputs through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| evt_valid | input | 1 | Checker beat carries an error flag |
| evt_sbe | input | 1 | Beat had a single-bit error |
| evt_mbe | input | 1 | Beat had a multi-bit error |
| evt_data | input | 64 | Beat data |
| evt_chk | input | 16 | Beat check bits |
| evt_addr | input | 64 | Beat address |
| wr_data_in | input | 64 | Write-path data before injection |
| wr_chk_in | input | 16 | Write-path check bits before injection |
| wr_data_out | output | 64 | Write-path data after injection |
| wr_chk_out | output | 16 | Write-path check bits after injection |
| irq | output | 1 | Error interrupt |

## Verification
The bench builds the block with its default 8-bit SBE counter. It programs only small thresholds (0 to 4), so reaching the threshold, wrapping the count and the zero-threshold case all occur within a few beats. A fixed-seed random mix of beats, clears, threshold rewrites and enable changes is compared against a bench model of the detect bits, the count and the locked snapshot. Directed cases add a clear colliding with a new error, bus-width masking of check bits, and injection.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;
    localparam int DATA_W  = 64;
    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 64;
    localparam int CHK_W   = 16;
    localparam int CHK_NW  = CHK_W / 2;
    localparam int REG_AW  = 4;
    localparam int THR_LSB = 16;
    localparam int INJ_EN  = CHK_W;

    typedef enum logic [REG_AW-1:0] {
        RA_CFG     = 4'd0,
        RA_DETECT  = 4'd1,
        RA_MASK    = 4'd2,
        RA_INTEN   = 4'd3,
        RA_SBEMGT  = 4'd4,
        RA_CAP_HI  = 4'd5,
        RA_CAP_LO  = 4'd6,
        RA_CAP_CHK = 4'd7,
        RA_ADR_LO  = 4'd8,
        RA_ADR_HI  = 4'd9,
        RA_INJ_HI  = 4'd10,
        RA_INJ_LO  = 4'd11,
        RA_INJ_CTL = 4'd12
    } reg_addr_e;

    typedef struct packed {
        logic mbe;
        logic sbe;
    } err_kind_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [CHK_W-1:0]  chk;
        logic [ADDR_W-1:0] addr;
    } cap_rec_t;

    function automatic logic [CHK_W-1:0] keep_chk(logic [CHK_W-1:0] c, logic narrow_bus);
        return narrow_bus ? c : {{(CHK_W-CHK_NW){1'b0}}, c[CHK_NW-1:0]};
    endfunction
endpackage

// File: rtl/ecc_sbe_counter.sv
module ecc_sbe_counter
    #(parameter int CNT_W = 8)
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sbe_hit,
    input  logic             thr_wr,
    input  logic [CNT_W-1:0] thr_wdata,
    output logic [CNT_W-1:0] thr_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             report
);
    logic [CNT_W:0] cnt_next;
    logic           counting;

    assign cnt_next = {1'b0, cnt_q} + 1'b1;
    assign counting = sbe_hit && (thr_q != '0);
    assign report   = counting && (cnt_next == {1'b0, thr_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= '0;
            cnt_q <= '0;
        end else begin
            if (thr_wr)
                thr_q <= thr_wdata;
            if (thr_wr || report)
                cnt_q <= '0;
            else if (counting)
                cnt_q <= cnt_next[CNT_W-1:0];
        end
    end

    // R5: count stays below a nonzero threshold
    assert_cnt_below_thr_R5: assert property (@(posedge clk) disable iff (rst)
        (thr_q != '0) |-> (cnt_q < thr_q));

    // R5: count returns to zero after a report
    assert_cnt_wraps_R5: assert property (@(posedge clk) disable iff (rst)
        report |=> (cnt_q == '0));
endmodule

// File: rtl/ecc_detect_reg.sv
module ecc_detect_reg
    import ecc_err_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  err_kind_t set,
    input  logic      clr_we,
    input  err_kind_t clr_mask,
    output err_kind_t det_q
);
    err_kind_t clr_eff;

    assign clr_eff = clr_we ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst)
            det_q <= '0;
        else
            det_q <= (det_q & ~clr_eff) | set;
    end

    // R4: an MBE is recorded on the next cycle
    assert_mbe_sets_R4: assert property (@(posedge clk) disable iff (rst)
        set.mbe |=> det_q.mbe);

    generate
        for (genvar b = 0; b < 2; b++) begin : g_clr
            // R6: a clear without a colliding error drops the bit
            assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (rst)
                (clr_eff[b] && !set[b]) |=> !det_q[b]);
        end
    endgenerate
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
    import ecc_err_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     take,
    input  logic     locked,
    input  cap_rec_t rec,
    output cap_rec_t cap_q
);
    always_ff @(posedge clk) begin
        if (rst)
            cap_q <= '0;
        else if (take && !locked)
            cap_q <= rec;
    end

    // R8: snapshot frozen while any detect bit is set
    assert_cap_locked_R8: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(cap_q));
endmodule

// File: rtl/ecc_inject_path.sv
module ecc_inject_path
    import ecc_err_pkg::*;
(
    input  logic [WORD_W-1:0] inj_hi,
    input  logic [WORD_W-1:0] inj_lo,
    input  logic [CHK_W:0]    inj_ctl,
    input  logic [DATA_W-1:0] data_in,
    input  logic [CHK_W-1:0]  chk_in,
    output logic [DATA_W-1:0] data_out,
    output logic [CHK_W-1:0]  chk_out
);
    logic enable;

    assign enable   = inj_ctl[INJ_EN];
    assign data_out = data_in ^ (enable ? {inj_hi, inj_lo} : '0);
    assign chk_out  = chk_in ^ (enable ? inj_ctl[CHK_W-1:0] : '0);
endmodule

// File: rtl/ecc_err_mgr.sv
module ecc_err_mgr
    import ecc_err_pkg::*;
#(
    parameter int CNT_W = 8
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              evt_valid,
    input  logic              evt_sbe,
    input  logic              evt_mbe,
    input  logic [DATA_W-1:0] evt_data,
    input  logic [CHK_W-1:0]  evt_chk,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic [DATA_W-1:0] wr_data_in,
    input  logic [CHK_W-1:0]  wr_chk_in,
    output logic [DATA_W-1:0] wr_data_out,
    output logic [CHK_W-1:0]  wr_chk_out,
    output logic              irq
);
    localparam int CFG_W = 2;

    logic [CFG_W-1:0]  cfg_q;
    err_kind_t         mask_q, inten_q;
    logic [WORD_W-1:0] inj_hi_q, inj_lo_q;
    logic [CHK_W:0]    inj_ctl_q;

    reg_addr_e ra;
    assign ra = reg_addr_e'(reg_addr);

    logic wr_cfg, wr_det, wr_mask, wr_inten, wr_thr;
    assign wr_cfg   = reg_we && (ra == RA_CFG);
    assign wr_det   = reg_we && (ra == RA_DETECT);
    assign wr_mask  = reg_we && (ra == RA_MASK);
    assign wr_inten = reg_we && (ra == RA_INTEN);
    assign wr_thr   = reg_we && (ra == RA_SBEMGT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            mask_q    <= '0;
            inten_q   <= '0;
            inj_hi_q  <= '0;
            inj_lo_q  <= '0;
            inj_ctl_q <= '0;
        end else if (reg_we) begin
            case (ra)
                RA_CFG:     cfg_q     <= reg_wdata[CFG_W-1:0];
                RA_MASK:    mask_q    <= reg_wdata[1:0];
                RA_INTEN:   inten_q   <= reg_wdata[1:0];
                RA_INJ_HI:  inj_hi_q  <= reg_wdata;
                RA_INJ_LO:  inj_lo_q  <= reg_wdata;
                RA_INJ_CTL: inj_ctl_q <= reg_wdata[CHK_W:0];
                default: ;
            endcase
        end
    end

    // event qualification
    logic accept, sbe_hit, mbe_hit;
    assign accept  = evt_valid && cfg_q[0];
    assign sbe_hit = accept && evt_sbe && !mask_q.sbe;
    assign mbe_hit = accept && evt_mbe && !mask_q.mbe;

    logic [CNT_W-1:0] thr_q, cnt_q;
    logic             sbe_report;

    ecc_sbe_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .sbe_hit  (sbe_hit),
        .thr_wr   (wr_thr),
        .thr_wdata(reg_wdata[THR_LSB +: CNT_W]),
        .thr_q    (thr_q),
        .cnt_q    (cnt_q),
        .report   (sbe_report)
    );

    err_kind_t det_set, det_q;
    assign det_set = '{mbe: mbe_hit, sbe: sbe_report};

    ecc_detect_reg u_det (
        .clk     (clk),
        .rst     (rst),
        .set     (det_set),
        .clr_we  (wr_det),
        .clr_mask(reg_wdata[1:0]),
        .det_q   (det_q)
    );

    cap_rec_t rec, cap_q;
    assign rec = '{data: evt_data, chk: keep_chk(evt_chk, cfg_q[1]), addr: evt_addr};

    ecc_err_capture u_cap (
        .clk   (clk),
        .rst   (rst),
        .take  (mbe_hit || sbe_report),
        .locked(|det_q),
        .rec   (rec),
        .cap_q (cap_q)
    );

    ecc_inject_path u_inj (
        .inj_hi  (inj_hi_q),
        .inj_lo  (inj_lo_q),
        .inj_ctl (inj_ctl_q),
        .data_in (wr_data_in),
        .chk_in  (wr_chk_in),
        .data_out(wr_data_out),
        .chk_out (wr_chk_out)
    );

    assign irq = |(det_q & inten_q);

    always_comb begin
        reg_rdata = '0;
        case (ra)
            RA_CFG:     reg_rdata[CFG_W-1:0] = cfg_q;
            RA_DETECT:  reg_rdata[1:0]       = det_q;
            RA_MASK:    reg_rdata[1:0]       = mask_q;
            RA_INTEN:   reg_rdata[1:0]       = inten_q;
            RA_SBEMGT: begin
                reg_rdata[THR_LSB +: CNT_W] = thr_q;
                reg_rdata[CNT_W-1:0]        = cnt_q;
            end
            RA_CAP_HI:  reg_rdata = cap_q.data[DATA_W-1:WORD_W];
            RA_CAP_LO:  reg_rdata = cap_q.data[WORD_W-1:0];
            RA_CAP_CHK: reg_rdata[CHK_W-1:0] = cap_q.chk;
            RA_ADR_LO:  reg_rdata = cap_q.addr[WORD_W-1:0];
            RA_ADR_HI:  reg_rdata = cap_q.addr[ADDR_W-1:WORD_W];
            RA_INJ_HI:  reg_rdata = inj_hi_q;
            RA_INJ_LO:  reg_rdata = inj_lo_q;
            RA_INJ_CTL: reg_rdata[CHK_W:0] = inj_ctl_q;
            default: ;
        endcase
    end

    // R2: with ECC off no error reaches the detect logic
    assert_off_ignores_R2: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q[0] && !wr_det && !wr_thr) |=> ($stable(det_q) && $stable(cnt_q)));

    // R7: interrupt falls once nothing enabled is pending
    assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        ((det_q & inten_q) == '0) |-> !irq);
endmodule

// File: tb/ecc_err_mgr_test.sv
module ecc_err_mgr_test;
    logic        clk = 0;
    logic        rst = 1;
    logic        reg_we = 0;
    logic [3:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        evt_valid = 0, evt_sbe = 0, evt_mbe = 0;
    logic [63:0] evt_data = 0, evt_addr = 0;
    logic [15:0] evt_chk = 0;
    logic [63:0] wr_data_in = 0, wr_data_out;
    logic [15:0] wr_chk_in = 0, wr_chk_out;
    logic        irq;

    always #5 clk = ~clk;

    ecc_err_mgr uut (.*);

    int total = 0, bad = 0;
    logic [1:0]  m_cfg = 0, m_mask = 0, m_inten = 0, m_det = 0;
    int          m_cnt = 0, m_thr = 0;
    logic [63:0] m_data = 0, m_addr = 0;
    logic [15:0] m_chk = 0;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
        case (a)
            0: m_cfg = d[1:0];
            1: m_det = m_det & ~d[1:0];
            2: m_mask = d[1:0];
            3: m_inten = d[1:0];
            4: begin m_thr = int'(d[23:16]); m_cnt = 0; end
            default: ;
        endcase
    endtask

    task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
        reg_addr = a;
        #1;
        chk(tag, {32'h0, reg_rdata}, {32'h0, exp});
    endtask

    task automatic m_event(bit s, bit m, logic [63:0] d, logic [15:0] c, logic [63:0] a);
        bit acc = m_cfg[0];
        bit sh = acc && s && !m_mask[0];
        bit mh = acc && m && !m_mask[1];
        bit rep = 0;
        if (sh && m_thr != 0) begin
            if (m_cnt + 1 == m_thr) begin rep = 1; m_cnt = 0; end
            else m_cnt++;
        end
        if ((rep || mh) && m_det == 0) begin
            m_data = d; m_addr = a;
            m_chk = m_cfg[1] ? c : {8'h0, c[7:0]};
        end
        m_det = m_det | {mh, rep};
    endtask

    task automatic ev(bit s, bit m, logic [63:0] d, logic [15:0] c, logic [63:0] a);
        @(negedge clk);
        evt_valid = 1; evt_sbe = s; evt_mbe = m;
        evt_data = d; evt_chk = c; evt_addr = a;
        @(negedge clk);
        evt_valid = 0;
        m_event(s, m, d, c, a);
    endtask

    task automatic cmp_all();
        rd(1, {30'h0, m_det}, "R4");
        rd(4, {8'h0, 8'(m_thr), 8'h0, 8'(m_cnt)}, "R5");
        rd(5, m_data[63:32], "R8");
        rd(6, m_data[31:0], "R8");
        rd(7, {16'h0, m_chk}, "R9");
        rd(8, m_addr[31:0], "R8");
        rd(9, m_addr[63:32], "R8");
        chk("R7", irq, |(m_det & m_inten));
    endtask

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog act=running exp=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed1234));
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1: reset state
        for (int a = 0; a < 13; a++) rd(4'(a), 32'h0, "R1");
        chk("R1", irq, 0);

        // R2: ECC off, errors ignored
        wr(3, 3); wr(4, 32'h0001_0000);
        ev(1, 1, 64'h1111, 16'h22, 64'h33);
        cmp_all();
        rd(1, 0, "R2");

        // R5 threshold 1, R8 capture, R7 irq
        wr(0, 1);
        ev(1, 0, 64'hDEADBEEF_01234567, 16'hA5C3, 64'h0000_0012_8000_0040);
        cmp_all();
        rd(5, 32'hDEADBEEF, "R8");
        rd(7, 32'h0000_00C3, "R9");
        chk("R7", irq, 1);
        // R8 lock: second error leaves snapshot
        ev(0, 1, 64'h5555, 16'h1, 64'h77);
        cmp_all();
        rd(6, 32'h01234567, "R8");
        rd(1, 3, "R4");
        // R6 clear all
        wr(1, 32'hFFFF_FFFF);
        cmp_all();
        rd(1, 0, "R6");
        chk("R7", irq, 0);

        // R5 threshold 3 and count clear on write
        wr(4, 32'h0003_0000);
        ev(1, 0, 64'h1, 16'h1, 64'h1);
        ev(1, 0, 64'h2, 16'h2, 64'h2);
        rd(4, 32'h0003_0002, "R5");
        rd(1, 0, "R5");
        ev(1, 0, 64'h3, 16'h3, 64'h3);
        rd(4, 32'h0003_0000, "R5");
        rd(1, 1, "R5");
        cmp_all();
        wr(1, 3);
        ev(1, 0, 64'h4, 16'h4, 64'h4);
        wr(4, 32'h0003_0000);
        rd(4, 32'h0003_0000, "R5");
        // R5 threshold 0 never reports
        wr(4, 0);
        repeat (4) ev(1, 0, 64'h9, 16'h9, 64'h9);
        rd(1, 0, "R5");
        rd(4, 0, "R5");

        // R3 masks
        wr(4, 32'h0001_0000);
        wr(2, 1);
        ev(1, 0, 64'h6, 16'h6, 64'h6);
        rd(1, 0, "R3");
        wr(2, 2);
        ev(0, 1, 64'h7, 16'h7, 64'h7);
        rd(1, 0, "R3");
        ev(1, 0, 64'h8, 16'h8, 64'h8);
        rd(1, 1, "R3");
        cmp_all();
        wr(2, 0); wr(1, 3);

        // R9 narrow bus keeps 16 check bits
        wr(0, 3);
        ev(0, 1, 64'hA, 16'hABCD, 64'hB);
        rd(7, 32'h0000_ABCD, "R9");
        wr(1, 3); wr(0, 1);
        ev(0, 1, 64'hA, 16'hABCD, 64'hB);
        rd(7, 32'h0000_00CD, "R9");

        // R6 set wins over a colliding clear
        @(negedge clk);
        reg_we = 1; reg_addr = 1; reg_wdata = 32'h2;
        evt_valid = 1; evt_sbe = 0; evt_mbe = 1; evt_data = 64'hC; evt_chk = 0; evt_addr = 64'hD;
        @(negedge clk);
        reg_we = 0; evt_valid = 0;
        rd(1, 2, "R6");
        // R7 per-bit enable
        wr(3, 1);
        chk("R7", irq, 0);
        wr(3, 2);
        chk("R7", irq, 1);
        wr(1, 3);
        m_det = 0;
        cmp_all();

        // R10 injection
        wr(10, 32'hF0F0_0001); wr(11, 32'h8000_0003); wr(12, 32'h0000_00FF);
        rd(10, 32'hF0F0_0001, "R10");
        rd(11, 32'h8000_0003, "R10");
        rd(12, 32'h0000_00FF, "R10");
        wr_data_in = 64'h1234_5678_9ABC_DEF0; wr_chk_in = 16'h0F0F;
        #1;
        chk("R10", wr_data_out, 64'h1234_5678_9ABC_DEF0);
        chk("R10", wr_chk_out, 16'h0F0F);
        wr(12, 32'h0001_00FF);
        #1;
        chk("R10", wr_data_out, 64'h1234_5678_9ABC_DEF0 ^ 64'hF0F0_0001_8000_0003);
        chk("R10", wr_chk_out, 16'h0FF0);

        // random mix against the model
        for (int i = 0; i < 400; i++) begin
            int r = int'($urandom % 10);
            if (r < 6) begin
                bit s = ($urandom % 3) != 0;
                bit m = ($urandom % 4) == 0;
                ev(s, m, {$urandom, $urandom}, 16'($urandom), {$urandom, $urandom});
            end else if (r < 8) begin
                wr(1, 32'($urandom % 4));
            end else if (r == 8) begin
                wr(4, (1 + $urandom % 4) << 16);
            end else begin
                wr(3, 32'($urandom % 4));
            end
            cmp_all();
        end
        finish_run();
    end
endmodule